// File: doc/BRIEF.md
# Inline Compression Marker Checker

This block sits in the read path of a memory controller. It looks at each fetched 64-byte line and decides whether the line holds a compressed pair of lines or a single plain line. It makes that decision without a separate metadata fetch. A 32-bit tag kept in the top four bytes of the line is compared with a configured "packed" value, and the result is qualified by a small collision table. That table lists the addresses of plain lines whose top four bytes happen to equal the packed value. A second configured value marks a stale slot, so that only one valid copy of a line exists in memory.

On the write side, the controller shows the block every plain (uncompressed) line it stores. When that line's tag bytes equal the packed value, the block records the address in the table. Otherwise it drops the address if the table holds it. The table has a fixed number of entries. If a new colliding address finds the table full, the block raises a sticky alarm. That alarm tells the controller to pick a new packed value and rebuild memory. Loading new values through the configuration port empties the table and clears the alarm.

Top module: `inline_marker_checker`

## Requirements
- R1: A configuration write (`cfg_we` high at a clock edge) loads `cfg_pack_val` as the packed value and `cfg_stale_val` as the stale value. Reads from the next cycle on are judged against the new values.
- R2: The tag field is bits [511:480] of the line (its last four bytes). A packed value placed anywhere else in the line does not make the line count as packed.
- R3: In the same cycle as `rd_valid`, `rd_packed` is high exactly when the tag equals the packed value and `rd_addr` is not in the collision table.
- R4: `rd_stale` is high in the same cycle when `rd_valid` is high, the tag equals the stale value and `rd_packed` is low.
- R5: While `rd_valid` is low, `rd_packed` and `rd_stale` are low whatever the data.
- R6: A plain-line write whose tag equals the packed value enters `wr_addr` into the table. A later read of that address carrying the packed value reports `rd_packed` low.
- R7: A plain-line write whose tag differs from the packed value removes `wr_addr` from the table. A later read of that address carrying the packed value reports `rd_packed` high.
- R8: Writing a colliding line for an address that the table already holds uses no further entry. With the table full, such a write does not raise the alarm.
- R9: A colliding write of a new address while all 16 entries are used sets `ovf_alarm` from the next cycle on and leaves the table unchanged. The alarm stays set until a configuration write.
- R10: A configuration write empties the collision table and clears `ovf_alarm`.
- R11: A read in the same cycle as a write to the same address is judged on the table contents from before that write.
- R12: After reset the table is empty, `ovf_alarm` is low, the packed value is 32'hC0DE5A5A and the stale value is 32'h0BADF00D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load both tag values, empty table, clear alarm |
| cfg_pack_val | input | 32 | New packed-line tag value |
| cfg_stale_val | input | 32 | New stale-slot tag value |
| rd_valid | input | 1 | Fetched line present this cycle |
| rd_addr | input | 32 | Line address of the fetched line |
| rd_data | input | 512 | Fetched line contents |
| wr_valid | input | 1 | A plain line is being stored this cycle |
| wr_addr | input | 32 | Line address of the stored line |
| wr_data | input | 512 | Stored line contents |
| rd_packed | output | 1 | Fetched line is a packed pair |
| rd_stale | output | 1 | Fetched slot holds a stale copy |
| ovf_alarm | output | 1 | Sticky collision-table overflow |

## Verification
The properties take for granted that the packed and stale values differ, and that `wr_valid` is only raised for plain lines, never for packed pairs. The stimulus only ever loads distinct value pairs. It stores only plain lines, whose tag bytes are chosen on purpose to either match or miss the packed value. The properties also expect that the alarm only rises after a colliding write. The bench therefore fills the table with distinct addresses before it tries the one write that should overflow.

// File: rtl/cmk_pkg.sv
package cmk_pkg;
    localparam int LINE_BYTES = 64;
    localparam int TAG_BYTES  = 4;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int TAG_W      = TAG_BYTES * 8;
    localparam int TAG_LSB    = LINE_W - TAG_W;
    localparam int ADDR_W     = 32;
    localparam int TBL_DEPTH  = 16;

    localparam logic [TAG_W-1:0] PACK_RST  = 32'hC0DE_5A5A;
    localparam logic [TAG_W-1:0] STALE_RST = 32'h0BAD_F00D;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        tag_t pack_val;
        tag_t stale_val;
    } tag_cfg_t;

    typedef enum logic [1:0] {
        V_NONE   = 2'd0,
        V_PLAIN  = 2'd1,
        V_PACKED = 2'd2,
        V_STALE  = 2'd3
    } verdict_e;

    function automatic tag_t tag_of(input line_t line);
        return line[TAG_LSB +: TAG_W];
    endfunction
endpackage

// File: rtl/cmk_cfg_regs.sv
module cmk_cfg_regs
    import cmk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  tag_cfg_t load_val,
    output tag_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.pack_val  <= PACK_RST;
            cfg.stale_val <= STALE_RST;
        end else if (load) begin
            cfg <= load_val;
        end
    end
endmodule

// File: rtl/cmk_collision_table.sv
module cmk_collision_table
    import cmk_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    input  logic          upd_en,
    input  logic          upd_insert,
    input  logic [AW-1:0] upd_addr,
    output logic          upd_overflow,
    output logic [DEPTH-1:0] occ
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld_q;
    logic [AW-1:0]     adr_q [DEPTH];
    logic [DEPTH-1:0]  look_m;
    logic [DEPTH-1:0]  upd_m;
    logic [IW-1:0]     free_idx;
    logic              free_any;
    logic              upd_hit;
    logic              do_ins;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign look_m[g] = vld_q[g] && (adr_q[g] == look_addr);
        assign upd_m[g]  = vld_q[g] && (adr_q[g] == upd_addr);
    end

    assign look_hit = |look_m;
    assign upd_hit  = |upd_m;
    assign occ      = vld_q;

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_idx = IW'(i);
                free_any = 1'b1;
            end
        end
    end

    assign do_ins       = upd_en && upd_insert && !upd_hit;
    assign upd_overflow = do_ins && !free_any;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            vld_q <= '0;
        end else if (upd_en) begin
            if (do_ins && free_any) begin
                vld_q[free_idx] <= 1'b1;
            end else if (!upd_insert) begin
                vld_q <= vld_q & ~upd_m;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_adr
        always_ff @(posedge clk) begin
            if (rst) begin
                adr_q[g] <= '0;
            end else if (do_ins && free_any && !clear && (free_idx == IW'(g))) begin
                adr_q[g] <= upd_addr;
            end
        end
    end
endmodule

// File: rtl/cmk_classifier.sv
module cmk_classifier
    import cmk_pkg::*;
(
    input  logic     valid,
    input  tag_t     tag,
    input  tag_cfg_t cfg,
    input  logic     listed,
    output verdict_e verdict
);
    always_comb begin
        if (!valid) begin
            verdict = V_NONE;
        end else if ((tag == cfg.pack_val) && !listed) begin
            verdict = V_PACKED;
        end else if (tag == cfg.stale_val) begin
            verdict = V_STALE;
        end else begin
            verdict = V_PLAIN;
        end
    end
endmodule

// File: rtl/inline_marker_checker.sv
module inline_marker_checker
    import cmk_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [31:0]  cfg_pack_val,
    input  logic [31:0]  cfg_stale_val,
    input  logic         rd_valid,
    input  logic [31:0]  rd_addr,
    input  logic [511:0] rd_data,
    input  logic         wr_valid,
    input  logic [31:0]  wr_addr,
    input  logic [511:0] wr_data,
    output logic         rd_packed,
    output logic         rd_stale,
    output logic         ovf_alarm
);
    tag_cfg_t cfg_cur;
    tag_cfg_t cfg_new;
    logic     listed;
    logic     ovf_now;
    logic     wr_collide;
    logic     alarm_q;
    verdict_e verdict;
    logic [TBL_DEPTH-1:0] occ;
    logic     unused_bits;

    assign cfg_new.pack_val  = cfg_pack_val;
    assign cfg_new.stale_val = cfg_stale_val;
    assign unused_bits = ^{rd_data[TAG_LSB-1:0], wr_data[TAG_LSB-1:0], occ};

    cmk_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_we),
        .load_val (cfg_new),
        .cfg      (cfg_cur)
    );

    assign wr_collide = (tag_of(wr_data) == cfg_cur.pack_val);

    cmk_collision_table #(.DEPTH(TBL_DEPTH), .AW(ADDR_W)) u_tbl (
        .clk          (clk),
        .rst          (rst),
        .clear        (cfg_we),
        .look_addr    (rd_addr),
        .look_hit     (listed),
        .upd_en       (wr_valid),
        .upd_insert   (wr_collide),
        .upd_addr     (wr_addr),
        .upd_overflow (ovf_now),
        .occ          (occ)
    );

    cmk_classifier u_cls (
        .valid   (rd_valid),
        .tag     (tag_of(rd_data)),
        .cfg     (cfg_cur),
        .listed  (listed),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_we) begin
            alarm_q <= 1'b0;
        end else if (ovf_now) begin
            alarm_q <= 1'b1;
        end
    end

    assign rd_packed = (verdict == V_PACKED);
    assign rd_stale  = (verdict == V_STALE);
    assign ovf_alarm = alarm_q;
endmodule

// File: rtl/cmk_checker.sv
module cmk_checker
    import cmk_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         cfg_we,
    input logic         rd_valid,
    input logic [511:0] rd_data,
    input logic         wr_valid,
    input logic [511:0] wr_data,
    input logic         rd_packed,
    input logic         rd_stale,
    input logic         ovf_alarm,
    input tag_cfg_t     cfg_cur,
    input logic [TBL_DEPTH-1:0] occ
);
    // R3: packed verdict needs the configured tag in the top bytes
    p_packed_tag_r3: assert property (@(posedge clk) disable iff (rst)
        rd_packed |-> (rd_valid && tag_of(rd_data) == cfg_cur.pack_val));

    // R4: the two verdicts never coincide
    p_one_verdict_r4: assert property (@(posedge clk) disable iff (rst)
        !(rd_packed && rd_stale));

    // R5: silent without a fetched line
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!rd_packed && !rd_stale));

    // R9: alarm rises only after a colliding write on a full table
    p_alarm_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_alarm) |-> $past(wr_valid && !cfg_we && (&occ)
                                   && tag_of(wr_data) == cfg_cur.pack_val));

    // R9: alarm is sticky until a configuration write
    p_alarm_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_alarm && !cfg_we) |=> ovf_alarm);

    // R10: configuration write empties the table and clears the alarm
    p_cfg_clears_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!ovf_alarm && occ == '0));

    // R6: occupancy changes by at most one entry per cycle outside a clear
    p_one_step_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($countones(occ ^ $past(occ)) <= 1));
endmodule

bind inline_marker_checker cmk_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .rd_packed (rd_packed),
    .rd_stale  (rd_stale),
    .ovf_alarm (ovf_alarm),
    .cfg_cur   (cfg_cur),
    .occ       (occ)
);

// File: tb/inline_marker_checker_tb_top.sv
module inline_marker_checker_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [31:0]  cfg_pack_val = '0;
    logic [31:0]  cfg_stale_val = '0;
    logic         rd_valid = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic [511:0] rd_data = '0;
    logic         wr_valid = 1'b0;
    logic [31:0]  wr_addr = '0;
    logic [511:0] wr_data = '0;
    logic         rd_packed;
    logic         rd_stale;
    logic         ovf_alarm;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] pk = 32'hC0DE5A5A;
    logic [31:0] st = 32'h0BADF00D;

    always #2.5 clk = ~clk;

    inline_marker_checker dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_pack_val(cfg_pack_val), .cfg_stale_val(cfg_stale_val),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_packed(rd_packed), .rd_stale(rd_stale), .ovf_alarm(ovf_alarm)
    );

    function automatic logic [511:0] mkline(input logic [31:0] top, input logic [31:0] fill);
        return {top, {15{fill}}};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // read probe: drive at negedge, sample 1 ns later, release
    task automatic probe(input logic [31:0] a, input logic [511:0] d, input logic v,
                         input logic exp_p, input logic exp_s, input string req);
        @(negedge clk);
        rd_valid = v; rd_addr = a; rd_data = d;
        #1;
        chk(req, rd_packed, exp_p);
        chk(req, rd_stale, exp_s);
        rd_valid = 1'b0;
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] top);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = mkline(top, 32'h1111_2222);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic load_cfg(input logic [31:0] p, input logic [31:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pack_val = p; cfg_stale_val = s;
        @(negedge clk);
        cfg_we = 1'b0;
        pk = p; st = s;
    endtask

    task automatic t_reset;
        chk("R12 alarm", ovf_alarm, 1'b0);
        probe(32'h100, mkline(32'hC0DE5A5A, 32'h0), 1'b1, 1'b1, 1'b0, "R12 pack reset");
        probe(32'h104, mkline(32'h0BADF00D, 32'h0), 1'b1, 1'b0, 1'b1, "R12 R4 stale reset");
        probe(32'h108, mkline(32'h55555555, 32'h0), 1'b1, 1'b0, 1'b0, "R3 plain");
    endtask

    task automatic t_idle;
        probe(32'h100, mkline(pk, 32'h0), 1'b0, 1'b0, 1'b0, "R5 idle pack");
        probe(32'h100, mkline(st, 32'h0), 1'b0, 1'b0, 1'b0, "R5 idle stale");
    endtask

    task automatic t_cfg;
        load_cfg(32'h12345678, 32'h9ABCDEF0);
        probe(32'h200, mkline(32'hC0DE5A5A, 32'h0), 1'b1, 1'b0, 1'b0, "R1 old pack");
        probe(32'h200, mkline(32'h12345678, 32'h0), 1'b1, 1'b1, 1'b0, "R1 new pack");
        probe(32'h200, mkline(32'h9ABCDEF0, 32'h0), 1'b1, 1'b0, 1'b1, "R1 new stale");
        probe(32'h200, {32'h0, {15{32'h12345678}}}, 1'b1, 1'b0, 1'b0, "R2 low bytes");
    endtask

    task automatic t_collide;
        store(32'hA00, pk);
        probe(32'hA00, mkline(pk, 32'h0), 1'b1, 1'b0, 1'b0, "R6 listed");
        probe(32'hB00, mkline(pk, 32'h0), 1'b1, 1'b1, 1'b0, "R3 other addr");
        store(32'hA00, 32'h77777777);
        probe(32'hA00, mkline(pk, 32'h0), 1'b1, 1'b1, 1'b0, "R7 removed");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 32'hC00; wr_data = mkline(pk, 32'h0);
        rd_valid = 1'b1; rd_addr = 32'hC00; rd_data = mkline(pk, 32'h0);
        #1;
        chk("R11 pre-write view", rd_packed, 1'b1);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        probe(32'hC00, mkline(pk, 32'h0), 1'b1, 1'b0, 1'b0, "R11 post-write");
    endtask

    task automatic t_fill;
        load_cfg(32'h2468ACE0, 32'h13579BDF);
        for (int i = 0; i < 16; i++) store(32'h4000 + 32'(i) * 64, pk);
        chk("R9 full no alarm", ovf_alarm, 1'b0);
        store(32'h4000, pk);
        chk("R8 repeat no alarm", ovf_alarm, 1'b0);
        probe(32'h4000 + 15 * 64, mkline(pk, 32'h0), 1'b1, 1'b0, 1'b0, "R8 last entry held");
        store(32'h9000, pk);
        chk("R9 alarm set", ovf_alarm, 1'b1);
        probe(32'h9000, mkline(pk, 32'h0), 1'b1, 1'b1, 1'b0, "R9 not stored");
        store(32'h4000, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 alarm sticky", ovf_alarm, 1'b1);
        load_cfg(32'h2468ACE0, 32'h13579BDF);
        chk("R10 alarm cleared", ovf_alarm, 1'b0);
        probe(32'h4040, mkline(pk, 32'h0), 1'b1, 1'b1, 1'b0, "R10 table empty");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_cfg();
        t_collide();
        t_same_cycle();
        t_fill();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule